// File: doc/BRIEF.md
# Store-Triggered Cache Line Cleaning Controller

This block sits next to an L1 write-back data cache. For each committed store it decides whether the line that was just written should also be cleaned. To clean a line means its dirty data is written out to the next memory level, so the line becomes non-dirty. A parity error found later on a clean line can then be recovered by reloading the line. Software programs a small set of entries. Each entry binds one static store instruction address to a cyclic cleaning pattern of up to K bits.

When a committed store's instruction address matches a valid entry, the block reads the pattern bit under that entry's pointer. A set bit requests a clean of the store's line, and a clear bit lets the store proceed alone. The pointer then moves one position and wraps after the programmed length, so the pattern repeats for as long as the store keeps executing. Stores that match no entry are never cleaned.

Clean requests go to the cache controller through a request/acknowledge handshake and are held in a two-deep queue. The store stream is stalled whenever that queue is full.

Top module: `store_clean_ctrl`

## Requirements
- R1: After reset `clean_req` is 0, `st_ready` is 1 and every entry is invalid, so no store is cleaned until an entry is programmed.
- R2: A store commits in a cycle where `st_valid` and `st_ready` are both 1. If it matches a valid entry whose current pattern bit is 1, `clean_req` is 1 in the following cycle and `clean_line` equals `st_daddr[DADDR_W-1:LINE_OFS]`. If that bit is 0, no clean is requested.
- R3: The pattern is read LSB first, starting at bit 0. Each matching committed store consumes one bit. After bit `cfg_len_m1` (length = `cfg_len_m1`+1) the pointer returns to bit 0. For example, with length 4 and pattern bits b0..b3 = 0,1,0,0, the 2nd, 6th, 10th and later matching stores are cleaned.
- R4: A store whose instruction address matches no valid entry requests no clean and leaves every entry's pointer unchanged.
- R5: When several valid entries hold the same instruction address, the lowest-index entry decides, and only that entry's pointer advances.
- R6: Once raised, `clean_req` stays 1 with `clean_line` unchanged until the cycle in which `clean_ack` is 1.
- R7: Up to two clean requests are queued and presented in arrival order. `st_ready` is 0 while two are pending, and a store held during that time is not committed.
- R8: Writing an entry (`cfg_we` with `cfg_idx`) loads its valid bit, address, pattern and length and sets its pointer to bit 0. Writing `cfg_valid` = 0 disables the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit for the written entry |
| cfg_iaddr | input | IADDR_W | Store instruction address for the entry |
| cfg_pattern | input | PAT_BITS | Cleaning pattern, bit 0 consumed first |
| cfg_len_m1 | input | PTR_W | Pattern length minus one |
| st_valid | input | 1 | Committed store presented |
| st_iaddr | input | IADDR_W | Instruction address of the store |
| st_daddr | input | DADDR_W | Data address of the store |
| st_ready | output | 1 | Store accepted; 0 stalls the store |
| clean_req | output | 1 | Clean request to the cache controller |
| clean_line | output | LINE_W | Line address to clean |
| clean_ack | input | 1 | Cache controller accepts the head request |

## Verification
The bench replays a store sequence across two entries and checks the exact store numbers at which each pattern produces a clean. A design that reads the pattern from the wrong end, or that advances the pointer on stores that do not match, would clean the wrong stores. It checks pattern wrap-around at a length shorter than K, duplicate addresses (a wrong priority cleans on the wrong entry's pattern), and reprogramming in mid-sequence, where a pointer left unreset would clean one store too early. It also fills the queue and holds a store against it, so that a lost, reordered or overwritten line address, or a store slipping through a stall, is caught.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned DEF_ENTRIES  = 2;
  localparam int unsigned DEF_PAT_BITS = 8;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_LINE_OFS = 4;
  localparam int unsigned DEF_Q_DEPTH  = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scc_entry.sv
module scc_entry #(
  parameter int unsigned IADDR_W  = 32,
  parameter int unsigned PAT_BITS = 8,
  parameter int unsigned PTR_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_valid,
  input  logic [IADDR_W-1:0] wr_iaddr,
  input  logic [PAT_BITS-1:0] wr_pattern,
  input  logic [PTR_W-1:0]   wr_len_m1,
  input  logic [IADDR_W-1:0] probe_iaddr,
  input  logic               advance,
  output logic               hit,
  output logic               cur_bit
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PAT_BITS - 1);

  logic                valid_q, valid_d;
  logic [IADDR_W-1:0]  iaddr_q, iaddr_d;
  logic [PAT_BITS-1:0] pat_q, pat_d;
  logic [PTR_W-1:0]    len_q, len_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;

  always_comb begin
    valid_d = valid_q;
    iaddr_d = iaddr_q;
    pat_d   = pat_q;
    len_d   = len_q;
    ptr_d   = ptr_q;
    if (wr_en) begin
      valid_d = wr_valid;
      iaddr_d = wr_iaddr;
      pat_d   = wr_pattern;
      len_d   = (wr_len_m1 > LAST) ? LAST : wr_len_m1;
      ptr_d   = '0;
    end else if (advance) begin
      ptr_d = (ptr_q >= len_q) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      iaddr_q <= '0;
      pat_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      iaddr_q <= iaddr_d;
      pat_q   <= pat_d;
      len_q   <= len_d;
      ptr_q   <= ptr_d;
    end
  end

  assign hit     = valid_q && (iaddr_q == probe_iaddr);
  assign cur_bit = pat_q[ptr_q];
endmodule

// File: rtl/scc_prio_sel.sv
module scc_prio_sel #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scc_clean_fifo.sv
module scc_clean_fifo #(
  parameter int unsigned W     = 28,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= '0;
        end else if (do_push && (wp_q == AW'(g))) begin
          mem_q[g] <= push_data;
        end
      end
    end
  endgenerate

  assign head  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/store_clean_ctrl.sv
module store_clean_ctrl #(
  parameter int unsigned N_ENTRIES = scc_pkg::DEF_ENTRIES,
  parameter int unsigned PAT_BITS  = scc_pkg::DEF_PAT_BITS,
  parameter int unsigned IADDR_W   = scc_pkg::DEF_ADDR_W,
  parameter int unsigned DADDR_W   = scc_pkg::DEF_ADDR_W,
  parameter int unsigned LINE_OFS  = scc_pkg::DEF_LINE_OFS,
  parameter int unsigned Q_DEPTH   = scc_pkg::DEF_Q_DEPTH,
  localparam int unsigned IDX_W    = scc_pkg::idx_width(N_ENTRIES),
  localparam int unsigned PTR_W    = scc_pkg::idx_width(PAT_BITS),
  localparam int unsigned LINE_W   = DADDR_W - LINE_OFS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_valid,
  input  logic [IADDR_W-1:0]  cfg_iaddr,
  input  logic [PAT_BITS-1:0] cfg_pattern,
  input  logic [PTR_W-1:0]    cfg_len_m1,
  input  logic                st_valid,
  input  logic [IADDR_W-1:0]  st_iaddr,
  input  logic [DADDR_W-1:0]  st_daddr,
  output logic                st_ready,
  output logic                clean_req,
  output logic [LINE_W-1:0]   clean_line,
  input  logic                clean_ack
);
  localparam int unsigned CNT_W = $clog2(Q_DEPTH + 1);

  logic [N_ENTRIES-1:0] hits, bits, grant;
  logic                 any_hit, st_fire, want_clean;
  logic                 q_empty, q_full;
  logic [CNT_W-1:0]     fifo_cnt;
  logic                 unused_ofs;

  assign unused_ofs = ^st_daddr[LINE_OFS-1:0];
  assign st_fire    = st_valid && st_ready;

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      scc_entry #(
        .IADDR_W (IADDR_W),
        .PAT_BITS(PAT_BITS),
        .PTR_W   (PTR_W)
      ) u_ent (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we && (cfg_idx == IDX_W'(g))),
        .wr_valid   (cfg_valid),
        .wr_iaddr   (cfg_iaddr),
        .wr_pattern (cfg_pattern),
        .wr_len_m1  (cfg_len_m1),
        .probe_iaddr(st_iaddr),
        .advance    (st_fire && grant[g]),
        .hit        (hits[g]),
        .cur_bit    (bits[g])
      );
    end
  endgenerate

  scc_prio_sel #(.N(N_ENTRIES)) u_sel (
    .hits (hits),
    .grant(grant),
    .any  (any_hit)
  );

  assign want_clean = st_fire && any_hit && |(grant & bits);

  scc_clean_fifo #(.W(LINE_W), .DEPTH(Q_DEPTH)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (want_clean),
    .push_data(st_daddr[DADDR_W-1:LINE_OFS]),
    .pop      (clean_ack),
    .head     (clean_line),
    .empty    (q_empty),
    .full     (q_full),
    .count    (fifo_cnt)
  );

  assign clean_req = !q_empty;
  assign st_ready  = !q_full;
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int unsigned N     = 2,
  parameter int unsigned LW    = 28,
  parameter int unsigned CW    = 2,
  parameter int unsigned DEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          clean_req,
  input logic [LW-1:0] clean_line,
  input logic          clean_ack,
  input logic          any_hit,
  input logic [N-1:0]  grant,
  input logic [CW-1:0] fifo_cnt
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_req && !clean_ack) |=> (clean_req && $stable(clean_line)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  assert_stall_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> clean_req);

  assert_nomatch_noclean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !any_hit && !(clean_req && clean_ack))
      |=> (fifo_cnt == $past(fifo_cnt)));

  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind store_clean_ctrl scc_checker #(
  .N    (N_ENTRIES),
  .LW   (LINE_W),
  .CW   (CNT_W),
  .DEPTH(Q_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .clean_req (clean_req),
  .clean_line(clean_line),
  .clean_ack (clean_ack),
  .any_hit   (any_hit),
  .grant     (grant),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/store_clean_ctrl_test.sv
module store_clean_ctrl_test;
  logic        clk, rst_n;
  logic        cfg_we, cfg_valid;
  logic [0:0]  cfg_idx;
  logic [31:0] cfg_iaddr;
  logic [7:0]  cfg_pattern;
  logic [2:0]  cfg_len_m1;
  logic        st_valid;
  logic [31:0] st_iaddr, st_daddr;
  logic        st_ready, clean_req, clean_ack;
  logic [27:0] clean_line;

  int tests, fails;
  bit done;

  store_clean_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_iaddr(cfg_iaddr), .cfg_pattern(cfg_pattern), .cfg_len_m1(cfg_len_m1),
    .st_valid(st_valid), .st_iaddr(st_iaddr), .st_daddr(st_daddr),
    .st_ready(st_ready), .clean_req(clean_req), .clean_line(clean_line),
    .clean_ack(clean_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {instruction address, data address, expected clean}
  localparam logic [64:0] VEC [13] = '{
    {32'h100, 32'h1000, 1'b0},
    {32'h200, 32'h1010, 1'b1},
    {32'h100, 32'h1020, 1'b1},
    {32'h300, 32'h1030, 1'b0},
    {32'h100, 32'h1040, 1'b0},
    {32'h200, 32'h1050, 1'b0},
    {32'h100, 32'h1060, 1'b0},
    {32'h100, 32'h1070, 1'b0},
    {32'h100, 32'h1080, 1'b1},
    {32'h200, 32'h1090, 1'b1},
    {32'h200, 32'h10a0, 1'b0},
    {32'h200, 32'h10b0, 1'b0},
    {32'h200, 32'h10c0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic program_entry(input logic idx, input logic v, input logic [31:0] ia,
                               input logic [7:0] pat, input logic [2:0] lm1);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v;
    cfg_iaddr = ia; cfg_pattern = pat; cfg_len_m1 = lm1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // one store, then checks the decision; acknowledges any clean
  task automatic store_check(input logic [31:0] ia, input logic [31:0] da,
                             input bit exp, input string req);
    @(posedge clk); #1;
    st_valid = 1'b1; st_iaddr = ia; st_daddr = da;
    @(posedge clk); #1;
    st_valid = 1'b0;
    check(clean_req == exp, req, {31'd0, clean_req}, {31'd0, exp});
    if (exp) begin
      check(clean_line == da[31:4], req, {4'd0, clean_line}, {4'd0, da[31:4]});
      clean_ack = 1'b1;
      @(posedge clk); #1;
      clean_ack = 1'b0;
    end
  endtask

  task automatic ack_one;
    clean_ack = 1'b1;
    @(posedge clk); #1;
    clean_ack = 1'b0;
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_iaddr = 0;
    cfg_pattern = 0; cfg_len_m1 = 0; st_valid = 0; st_iaddr = 0; st_daddr = 0;
    clean_ack = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check(clean_req == 1'b0, "R1", {31'd0, clean_req}, 32'd0);
    check(st_ready == 1'b1, "R1", {31'd0, st_ready}, 32'd1);
    store_check(32'h100, 32'h2000, 1'b0, "R1");

    // table walk: entry0 len 4 bits 0,1,0,0; entry1 len 8 bits 1,0,1,0,0,1,0,1 (R2 R3 R4)
    program_entry(1'b0, 1'b1, 32'h100, 8'b0000_0010, 3'd3);
    program_entry(1'b1, 1'b1, 32'h200, 8'b1010_0101, 3'd7);
    foreach (VEC[i]) begin
      store_check(VEC[i][64:33], VEC[i][32:1], VEC[i][0],
                  (VEC[i][64:33] == 32'h300) ? "R4" : "R3");
    end

    // R5 duplicate address: entry0 always cleans, entry1 never
    program_entry(1'b0, 1'b1, 32'h400, 8'h01, 3'd0);
    program_entry(1'b1, 1'b1, 32'h400, 8'h00, 3'd0);
    store_check(32'h400, 32'h3000, 1'b1, "R5");
    store_check(32'h400, 32'h3010, 1'b1, "R5");
    // R8 disable entry0: entry1 now decides
    program_entry(1'b0, 1'b0, 32'h400, 8'h01, 3'd0);
    store_check(32'h400, 32'h3020, 1'b0, "R8");

    // R8 reprogram resets pointer: bits 0,1
    program_entry(1'b1, 1'b1, 32'h500, 8'b10, 3'd1);
    store_check(32'h500, 32'h4000, 1'b0, "R8");
    program_entry(1'b1, 1'b1, 32'h500, 8'b10, 3'd1);
    store_check(32'h500, 32'h4010, 1'b0, "R8");
    store_check(32'h500, 32'h4020, 1'b1, "R8");

    // R6 R7 queue fill and stall
    program_entry(1'b0, 1'b1, 32'h600, 8'h01, 3'd0);
    @(posedge clk); #1;
    st_valid = 1'b1; st_iaddr = 32'h600; st_daddr = 32'h5000;
    @(posedge clk); #1;
    st_daddr = 32'h5010;
    @(posedge clk); #1;
    st_daddr = 32'h5020;
    check(st_ready == 1'b0, "R7", {31'd0, st_ready}, 32'd0);
    @(posedge clk); #1;
    check(clean_req && clean_line == 28'h500, "R6", {4'd0, clean_line}, 32'h500);
    check(st_ready == 1'b0, "R7", {31'd0, st_ready}, 32'd0);
    ack_one;
    check(clean_line == 28'h501, "R7", {4'd0, clean_line}, 32'h501);
    @(posedge clk); #1;
    st_valid = 1'b0;
    check(st_ready == 1'b0 && clean_line == 28'h501, "R7", {4'd0, clean_line}, 32'h501);
    ack_one;
    check(clean_req && clean_line == 28'h502, "R7", {4'd0, clean_line}, 32'h502);
    ack_one;
    check(clean_req == 1'b0, "R7", {31'd0, clean_req}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule